// File: doc/BRIEF.md
# Bitonic 4+4 Key Merge Pipeline

This block merges two short sorted key lists into one sorted list of twice the length. Each input is a vector of four unsigned 32-bit keys, already in ascending order with lane 0 holding the smallest key. The block places the first list in lanes 0 to 3 of an eight-lane working vector. It places the second list, reversed in lane order, in lanes 4 to 7. The concatenation then rises and then falls, which is a bitonic sequence. A bitonic sequence can be sorted by a fixed cascade of half-cleaners.

Three comparator levels follow, at lane distances 4, 2 and 1. Each level is one vector-wide minimum and one vector-wide maximum, joined to the next level only by fixed lane wiring. No lane is masked or blended. A register sits after each level, so a merge takes three clock cycles and a new merge may enter on every cycle. The result leaves as a low vector holding the four smallest keys and a high vector holding the four largest, both in ascending order.

The pipeline has no states beyond its three valid bits. It has two named conditions: RESET, in which every stage is cleared, and RUN, in which each stage takes the value of the stage before it on every clock. The only transition is RESET to RUN, when the active-low reset is released.

Top module: `bitonic_merge8`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `out_lo` and `out_hi` are all zeros. A reset issued while merges are in flight discards them, so no `out_valid` pulse follows from them.
- R2: `out_valid` equals the value `in_valid` had exactly three rising clock edges earlier. A single-cycle `in_valid` pulse gives a single-cycle `out_valid` pulse three cycles later.
- R3: When `out_valid` is 1, `out_lo` holds the four smallest of the eight input keys in ascending order. Lane k of a vector occupies bits [32k+31:32k], and lane 0 is the smallest.
- R4: When `out_valid` is 1, `out_hi` holds the four largest of the eight input keys in ascending order, and `out_hi` lane 0 is not smaller than `out_lo` lane 3.
- R5: The eight output keys are exactly the eight input keys, duplicates included. No key is lost or repeated.
- R6: Keys compare as unsigned numbers, so 32'hFFFFFFFF is the largest key and 0 is the smallest.
- R7: A new pair of vectors may be accepted on every clock cycle. Back-to-back merges leave on consecutive cycles, each with its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The input vectors hold a pair to merge |
| in_a | input | 128 | First sorted vector, lane 0 smallest |
| in_b | input | 128 | Second sorted vector, lane 0 smallest |
| out_valid | output | 1 | The output vectors hold a merged result |
| out_lo | output | 128 | Four smallest keys, ascending |
| out_hi | output | 128 | Four largest keys, ascending |

## Verification
The hardest situation to reach from the ports is a pipeline that holds three different merges at once, each at a different level, while a merge that just left could leak into a neighbour. The bench reaches it by streaming a table of vector pairs into the block on consecutive cycles. Some pairs need swaps at every level, some are all-equal, and some span the full unsigned range. A separate pulse test and a reset issued with a merge in flight cover the valid timing and the flushing of merges already inside the pipeline.

// File: rtl/bmrg_pkg.sv
package bmrg_pkg;
    localparam int KEY_W_DEF = 32;
    localparam int LANES_DEF = 4;

    typedef enum logic [0:0] {
        PIPE_RESET = 1'b0,
        PIPE_RUN   = 1'b1
    } pipe_mode_t;
endpackage

// File: rtl/bmrg_lane_reverse.sv
module bmrg_lane_reverse #(
    parameter int KEY_W = 32,
    parameter int LANES = 4
) (
    input  logic [LANES*KEY_W-1:0] din,
    output logic [LANES*KEY_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*KEY_W +: KEY_W] = din[(LANES-1-i)*KEY_W +: KEY_W];
    end
endmodule

// File: rtl/bmrg_cas_level.sv
module bmrg_cas_level #(
    parameter int KEY_W = 32,
    parameter int WIDTH = 8,
    parameter int DIST  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [WIDTH*KEY_W-1:0] in_keys,
    output logic                   out_valid,
    output logic [WIDTH*KEY_W-1:0] out_keys
);
    logic [WIDTH*KEY_W-1:0] nxt_keys;

    // Pair lane i with lane i+DIST wherever bit DIST of i is clear.
    // The smaller key goes to the lower lane.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        if ((i & DIST) == 0) begin : g_cmp
            logic [KEY_W-1:0] low_k;
            logic [KEY_W-1:0] high_k;
            logic             swap;
            assign low_k  = in_keys[i*KEY_W +: KEY_W];
            assign high_k = in_keys[(i+DIST)*KEY_W +: KEY_W];
            assign swap   = high_k < low_k;
            assign nxt_keys[i*KEY_W +: KEY_W]        = swap ? high_k : low_k;
            assign nxt_keys[(i+DIST)*KEY_W +: KEY_W] = swap ? low_k  : high_k;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_keys  <= '0;
        end else begin
            out_valid <= in_valid;
            out_keys  <= nxt_keys;
        end
    end
endmodule

// File: rtl/bitonic_merge8.sv
module bitonic_merge8 #(
    parameter int KEY_W = bmrg_pkg::KEY_W_DEF,
    parameter int LANES = bmrg_pkg::LANES_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*KEY_W-1:0] in_a,
    input  logic [LANES*KEY_W-1:0] in_b,
    output logic                   out_valid,
    output logic [LANES*KEY_W-1:0] out_lo,
    output logic [LANES*KEY_W-1:0] out_hi
);
    localparam int WIDTH  = 2 * LANES;
    localparam int VEC_W  = WIDTH * KEY_W;
    localparam int LEVELS = $clog2(WIDTH);

    logic [LANES*KEY_W-1:0] b_rev;
    logic [VEC_W-1:0]       stage_keys  [LEVELS+1];
    logic                   stage_valid [LEVELS+1];

    bmrg_lane_reverse #(.KEY_W(KEY_W), .LANES(LANES)) i_rev (
        .din  (in_b),
        .dout (b_rev)
    );

    // Ascending run in lanes 0..LANES-1, descending run above: bitonic.
    assign stage_keys[0]  = {b_rev, in_a};
    assign stage_valid[0] = in_valid;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        bmrg_cas_level #(
            .KEY_W (KEY_W),
            .WIDTH (WIDTH),
            .DIST  (WIDTH >> (l + 1))
        ) i_lvl (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (stage_valid[l]),
            .in_keys   (stage_keys[l]),
            .out_valid (stage_valid[l+1]),
            .out_keys  (stage_keys[l+1])
        );
    end

    assign out_valid = stage_valid[LEVELS];
    assign out_lo    = stage_keys[LEVELS][0 +: LANES*KEY_W];
    assign out_hi    = stage_keys[LEVELS][LANES*KEY_W +: LANES*KEY_W];
endmodule

// File: rtl/bmrg_checker.sv
module bmrg_checker #(
    parameter int KEY_W = 32,
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [LANES*KEY_W-1:0] in_a,
    input logic [LANES*KEY_W-1:0] in_b,
    input logic                   out_valid,
    input logic [LANES*KEY_W-1:0] out_lo,
    input logic [LANES*KEY_W-1:0] out_hi
);
    localparam int LEVELS = $clog2(2 * LANES);
    localparam int SUM_W  = KEY_W + LEVELS + 1;
    localparam int AGE_W  = $clog2(LEVELS + 1) + 1;

    logic [AGE_W-1:0] age;
    logic             vhist [LEVELS];
    logic [SUM_W-1:0] shist [LEVELS];
    logic [SUM_W-1:0] in_sum, out_sum;
    logic             lo_ok, hi_ok;

    always_comb begin
        in_sum  = '0;
        out_sum = '0;
        lo_ok   = 1'b1;
        hi_ok   = out_hi[0 +: KEY_W] >= out_lo[(LANES-1)*KEY_W +: KEY_W];
        for (int i = 0; i < LANES; i++) begin
            in_sum  = in_sum  + SUM_W'(in_a[i*KEY_W +: KEY_W])   + SUM_W'(in_b[i*KEY_W +: KEY_W]);
            out_sum = out_sum + SUM_W'(out_lo[i*KEY_W +: KEY_W]) + SUM_W'(out_hi[i*KEY_W +: KEY_W]);
        end
        for (int i = 0; i < LANES - 1; i++) begin
            if (out_lo[i*KEY_W +: KEY_W] > out_lo[(i+1)*KEY_W +: KEY_W]) lo_ok = 1'b0;
            if (out_hi[i*KEY_W +: KEY_W] > out_hi[(i+1)*KEY_W +: KEY_W]) hi_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
            for (int k = 0; k < LEVELS; k++) begin
                vhist[k] <= 1'b0;
                shist[k] <= '0;
            end
        end else begin
            if (age != AGE_W'(LEVELS)) age <= age + 1'b1;
            vhist[0] <= in_valid;
            shist[0] <= in_sum;
            for (int k = 1; k < LEVELS; k++) begin
                vhist[k] <= vhist[k-1];
                shist[k] <= shist[k-1];
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid)
        else $error("R1: out_valid after reset");
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == AGE_W'(LEVELS)) |-> (out_valid == vhist[LEVELS-1]))
        else $error("R2: valid latency");
    p_lo_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lo_ok)
        else $error("R3: low vector not ascending");
    p_hi_sorted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hi_ok)
        else $error("R4: high vector not ascending or overlaps low");
    p_keep_keys_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == AGE_W'(LEVELS) && out_valid) |-> (out_sum == shist[LEVELS-1]))
        else $error("R5: key sum changed");
endmodule

bind bitonic_merge8 bmrg_checker #(.KEY_W(KEY_W), .LANES(LANES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_lo    (out_lo),
    .out_hi    (out_hi)
);

// File: tb/test_bitonic_merge8.sv
`timescale 1ns/1ps
module test_bitonic_merge8;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_lo, out_hi;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bitonic_merge8 i_bitonic_merge8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi)
    );

    // Each entry is {in_b, in_a}; each vector is {lane3, lane2, lane1, lane0}.
    localparam int NV = 8;
    localparam logic [255:0] VECS [NV] = '{
        {32'd400, 32'd300, 32'd200, 32'd100,  32'd4, 32'd3, 32'd2, 32'd1},
        {32'd4, 32'd3, 32'd2, 32'd1,          32'd40, 32'd30, 32'd20, 32'd10},
        {32'd8, 32'd6, 32'd4, 32'd2,          32'd7, 32'd5, 32'd3, 32'd1},
        {32'd5, 32'd5, 32'd5, 32'd5,          32'd5, 32'd5, 32'd5, 32'd5},
        {32'd9, 32'd9, 32'd9, 32'd0,          32'd9, 32'd9, 32'd0, 32'd0},
        {32'hFFFFFFFF, 32'hFFFFFFFE, 32'h80000001, 32'h80000000,
         32'hFFFFFFFF, 32'd2, 32'd1, 32'd0},
        {32'd12, 32'd11, 32'd1, 32'd0,        32'd10, 32'd9, 32'd8, 32'd7},
        {32'd170, 32'd160, 32'd150, 32'd50,   32'd103, 32'd102, 32'd101, 32'd100}
    };

    function automatic logic [255:0] sorted8(input logic [255:0] v);
        logic [31:0] k [8];
        logic [31:0] t;
        logic [255:0] r;
        for (int i = 0; i < 8; i++) k[i] = v[i*32 +: 32];
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 7 - i; j++)
                if (k[j] > k[j+1]) begin
                    t = k[j]; k[j] = k[j+1]; k[j+1] = t;
                end
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = k[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [255:0] pair);
        in_valid = v;
        in_a     = pair[127:0];
        in_b     = pair[255:128];
    endtask

    initial begin
        logic [255:0] exp;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check("R1 reset out_valid", 128'(out_valid), 128'd0);
        check("R1 reset out_lo", out_lo, '0);
        check("R1 reset out_hi", out_hi, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle out_valid", 128'(out_valid), 128'd0);

        // R7: table streamed one pair per cycle; output at negedge c is input of c-3
        for (int c = 0; c < NV + 3; c++) begin
            if (c >= 3) begin
                exp = sorted8(VECS[c-3]);
                check("R7/R2 stream out_valid", 128'(out_valid), 128'd1);
                check("R3/R5 low vector", out_lo, exp[127:0]);
                check("R4/R5 high vector", out_hi, exp[255:128]);
            end
            if (c < NV) drive(1'b1, VECS[c]);
            else        drive(1'b0, '0);
            @(negedge clk);
        end
        check("R2 idle after stream", 128'(out_valid), 128'd0);

        // R2: single pulse timing
        drive(1'b1, VECS[2]);
        @(negedge clk); drive(1'b0, '0);
        check("R2 pulse +1", 128'(out_valid), 128'd0);
        @(negedge clk);
        check("R2 pulse +2", 128'(out_valid), 128'd0);
        @(negedge clk);
        check("R2 pulse +3", 128'(out_valid), 128'd1);
        @(negedge clk);
        check("R2 pulse +4", 128'(out_valid), 128'd0);

        // R6: unsigned ordering at the range ends
        drive(1'b1, {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000001,
                     32'hFFFFFFFF, 32'h80000000, 32'h00000003, 32'h00000000});
        @(negedge clk); drive(1'b0, '0);
        repeat (2) @(negedge clk);
        check("R6 largest key on top", 128'(out_hi[127:96]), 128'(32'hFFFFFFFF));
        check("R6 zero at bottom", 128'(out_lo[31:0]), 128'd0);
        check("R6 high lane0", 128'(out_hi[31:0]), 128'(32'h80000000));

        // R1: reset with merges in flight discards them
        drive(1'b1, VECS[0]);
        @(negedge clk); drive(1'b1, VECS[1]);
        @(negedge clk); drive(1'b0, '0); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 flush cycle0", 128'(out_valid), 128'd0);
        @(negedge clk);
        check("R1 flush cycle1", 128'(out_valid), 128'd0);
        check("R1 flush out_lo", out_lo, '0);
        @(negedge clk);
        check("R1 flush cycle2", 128'(out_valid), 128'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule